// File: doc/BRIEF.md
# Periodic Limit Counter-Timer

A word-addressed counter-timer that advances on an external tick-enable pulse, compares its count with a programmable limit, and wraps to zero when the two meet. Each match sets a sticky flag and raises an interrupt. Software acknowledges the interrupt by reading or rewriting the limit. A limit of zero makes the counter run freely over its full range.

The count is 22 bits wide. In every 32-bit bus word it sits in bits 30..9, so each tick adds 0x200 to the value software sees. Bits 8..0 always read as zero, and bit 31 of the counter word carries the flag. Two write offsets program the limit. One restarts the count from zero. The other swaps the limit while the count keeps running. Read data is registered and appears one cycle after the read strobe.

Top module: `cnt_limit_timer`

## Requirements
- R1: After reset the limit and count are zero, the flag is clear, `irq` is low, and the counter free-runs.
- R2: A cycle with `tick` high and no limit write adds one to the count (0x200 in the counter word). Without a tick the count holds.
- R3: A read of word 1 returns {flag, count, 9'b0} in `rdata` on the cycle after `rd_en`. Bits 8..0 of `rdata` are always zero.
- R4: A write to word 0 stores `wdata[30:9]` as the limit and ignores bits 31 and 8..0. It clears the count and drops `irq`, and it leaves the flag unchanged.
- R5: When a tick brings the count up to a non-zero limit, the count becomes zero on that same tick, and the flag and `irq` are set.
- R6: With a limit of zero the wrap point is count 0x3FFFFF (word value 0x7FFFFE00), so small counts never set the flag.
- R7: A write to word 2 replaces the limit without changing the count, the flag or `irq`.
- R8: A read of word 0 returns {1'b0, limit, 9'b0}, and it clears both the flag and `irq`.
- R9: `irq` stays high across further matches and across counter reads until word 0 is read or written.
- R10: Reads of words 2 to 7 return zero. Writes to words 1 and 3 to 7 change nothing.
- R11: A limit write in the same cycle as a tick leaves the count at zero. A match in the same cycle as a limit read leaves the flag and `irq` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable, one per time unit |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Match interrupt, level |

## Verification
Count, limit, flag and `irq` all change at the clock edge that samples the tick or strobe. The bench therefore checks `irq` at the falling edge right after that edge. Read data lands one edge after `rd_en`. The driver queues the expected word when it raises the strobe, and the monitor compares it at the falling edge that follows the capturing edge. Ticks are never issued in the same cycle as a read, except in the deliberate R11 collision case.

// File: rtl/cnt_limit_timer.sv
module cnt_limit_timer #(
  parameter int CNT_W  = 22,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int FRAC_W = 31 - CNT_W;
  localparam logic [ADDR_W-1:0] A_LIM = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_NRS = ADDR_W'(2);

  logic [CNT_W-1:0] cnt_q, lim_q, eff_lim, cnt_inc;
  logic             flag_q, hit;

  wire wr_lim = wr_en && addr == A_LIM;
  wire wr_nrs = wr_en && addr == A_NRS;
  wire rd_lim = rd_en && addr == A_LIM;

  assign eff_lim = (lim_q == '0) ? '1 : lim_q;
  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = tick && !wr_lim && (cnt_inc == eff_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      flag_q <= 1'b0;
      irq    <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr_lim)    cnt_q <= '0;
      else if (tick) cnt_q <= hit ? '0 : cnt_inc;

      if (wr_lim || wr_nrs) lim_q <= wdata[30:FRAC_W];

      if (hit)         flag_q <= 1'b1;
      else if (rd_lim) flag_q <= 1'b0;

      if (hit)                   irq <= 1'b1;
      else if (rd_lim || wr_lim) irq <= 1'b0;

      if (rd_en) begin
        case (addr)
          A_LIM:   rdata <= {1'b0, lim_q, {FRAC_W{1'b0}}};
          A_CNT:   rdata <= {flag_q, cnt_q, {FRAC_W{1'b0}}};
          default: rdata <= '0;
        endcase
      end
    end
  end

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_lim) |=> $stable(cnt_q));
  a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[FRAC_W-1:0] == '0);
  a_r4_restart_on_limit_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_LIM) |=> cnt_q == '0);
  a_r5_wrap_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> cnt_q == '0);
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);
  a_r9_irq_drop_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past((rd_en || wr_en) && addr == A_LIM));
endmodule

// File: tb/cnt_limit_timer_tb.sv
module cnt_limit_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_vec = 0, n_bad = 0;
  logic        rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cnt_limit_timer u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_vec++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_irq(1'b0, "R1 irq after reset");
    rd(3'd1, 32'h0, "R1 count after reset");
    rd(3'd0, 32'h0, "R1 limit after reset");

    ticks(5);
    rd(3'd1, 32'h0000_0A00, "R2 R3 five ticks");
    repeat (3) @(negedge clk);
    rd(3'd1, 32'h0000_0A00, "R2 hold without tick");

    ticks(2);
    wr(3'd0, 32'h8000_0BFF);
    rd(3'd0, 32'h0000_0A00, "R4 masked limit");
    rd(3'd1, 32'h0, "R4 count restarted");
    chk_irq(1'b0, "R4 irq low");

    ticks(4);
    rd(3'd1, 32'h0000_0800, "R5 below limit");
    chk_irq(1'b0, "R5 no match yet");
    ticks(1);
    chk_irq(1'b1, "R5 irq on match");
    rd(3'd1, 32'h8000_0000, "R5 wrap and flag");
    chk_irq(1'b1, "R9 counter read keeps irq");

    ticks(5);
    chk_irq(1'b1, "R9 second match");
    rd(3'd1, 32'h8000_0000, "R9 flag after second match");
    rd(3'd0, 32'h0000_0A00, "R8 limit read");
    chk_irq(1'b0, "R8 irq cleared");
    rd(3'd1, 32'h0, "R8 flag cleared");

    ticks(2);
    wr(3'd2, 32'h0000_0600);
    rd(3'd1, 32'h0000_0400, "R7 count kept");
    ticks(1);
    chk_irq(1'b1, "R7 new limit matched");
    rd(3'd0, 32'h0000_0600, "R7 limit updated");

    ticks(3);
    chk_irq(1'b1, "R7 match again");
    wr(3'd2, 32'h0000_0600);
    chk_irq(1'b1, "R7 word2 keeps irq");
    wr(3'd0, 32'h0000_0600);
    chk_irq(1'b0, "R4 limit write drops irq");
    rd(3'd1, 32'h8000_0000, "R4 flag unchanged by limit write");
    rd(3'd0, 32'h0000_0600, "R8 ack");

    ticks(1);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, 32'h0000_0200, "R10 count untouched");
    rd(3'd0, 32'h0000_0600, "R10 limit untouched");
    chk_irq(1'b0, "R10 irq untouched");
    rd(3'd2, 32'h0, "R10 word2 reads zero");
    rd(3'd3, 32'h0, "R10 word3 reads zero");
    rd(3'd4, 32'h0, "R10 word4 reads zero");
    rd(3'd6, 32'h0, "R10 word6 reads zero");

    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 32'h0000_0600;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(3'd1, 32'h0, "R11 write beats tick");
    ticks(2);
    @(negedge clk);
    tick = 1'b1; rd_en = 1'b1; addr = 3'd0;
    exp_q.push_back(32'h0000_0600); tag_q.push_back("R11 limit read during match");
    @(negedge clk);
    tick = 1'b0; rd_en = 1'b0;
    chk_irq(1'b1, "R11 match beats ack");
    rd(3'd1, 32'h8000_0000, "R11 flag kept");
    rd(3'd0, 32'h0000_0600, "R11 ack");

    wr(3'd0, 32'h0);
    ticks(300);
    rd(3'd1, 32'h0002_5800, "R6 free run past small counts");
    chk_irq(1'b0, "R6 no match in free run");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule